// File: doc/BRIEF.md
# Three-Product Sequential 16x16 Multiplier

This block forms the exact unsigned 32-bit product of two unsigned 16-bit operands. Each operand is treated as two base-256 digits, a high byte and a low byte. Four byte-by-byte partial products would normally be needed. This block uses three: the product of the two high bytes, the product of the two low bytes, and one signed cross term built from byte differences. All three run one after another through a single shared signed 9x9 multiplier. A wide signed accumulator then adds them back together with byte shifts.

A caller puts both operands on the inputs and raises `start` for one cycle while the block is idle. The controller steps through the states IDLE, MUL_H, MUL_L, MUL_M, COMB and DONE, one cycle each. The transitions are:
- IDLE to MUL_H when a start is accepted.
- MUL_H to MUL_L, MUL_L to MUL_M, MUL_M to COMB, COMB to DONE and DONE to IDLE, each taken on every clock without condition.
- IDLE to IDLE when `start` is low.

`done` is high during DONE. The result appears in the same cycle and stays on `product` until the next result replaces it.

Top module: `kara_mul16`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done` is 0 and `product` is 0.
- R2: For every operand pair, the `product` presented with `done` equals the exact unsigned product op_a*op_b, taken modulo 2^32 (which is exact for 16-bit operands).
- R3: When a start is accepted at clock edge k, `done` is high only between edges k+4 and k+5. It is high for exactly one cycle per accepted start.
- R4: `product` changes only at the edge where `done` rises. At every other edge it holds its value.
- R5: A `start` that is high while the block is in any state other than IDLE has no effect. This includes the DONE cycle. Neither timing nor result changes.
- R6: Operands are sampled only at the edge where a start is accepted. Later changes on `op_a` and `op_b` do not affect the result.
- R7: When either operand is 0x0000, the result is 0x00000000.
- R8: Both operands 0xFFFF give 0xFFFE0001.
- R9: The cross term is (a_hi - a_lo)*(b_lo - b_hi), with each difference a 9-bit two's-complement value in -255..+255. The result is exact when one difference is negative and the other positive, and also when both have the same sign.
- R10: The signed recombination sum H*(2^16+2^8) + M*2^8 + L*(2^8+1) never leaves the range 0..2^32-1 in its 34-bit accumulator, even for the most negative cross term (for example 0xFF00*0xFF00 = 0xFE010000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; honoured only in IDLE |
| op_a | input | 16 | Multiplicand, sampled when start is accepted |
| op_b | input | 16 | Multiplier, sampled when start is accepted |
| done | output | 1 | One-cycle pulse marking a new result |
| product | output | 32 | Unsigned result, held until the next result |

## Verification
The bound checker watches the controller on every cycle. It checks that each state advances exactly as listed, that a start is taken only in IDLE, that `done` follows COMB and lasts one cycle, and that `product` changes only when leaving COMB. It also checks that the accumulator stays within 32 unsigned bits and that no byte difference reaches -256. The arithmetic itself is left to the bench: exactness for zeros, all-ones, mixed-sign and same-sign differences and thousands of random pairs. The bench also shows that ignored starts and operand changes while busy leave the result untouched.

// File: rtl/kara_pkg.sv
package kara_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MUL_H = 3'd1,
        ST_MUL_L = 3'd2,
        ST_MUL_M = 3'd3,
        ST_COMB  = 3'd4,
        ST_DONE  = 3'd5
    } kara_state_e;

    typedef enum logic [1:0] {
        TERM_H = 2'd0,
        TERM_L = 2'd1,
        TERM_M = 2'd2
    } kara_term_e;

endpackage

// File: rtl/kara_fsm.sv
module kara_fsm
    import kara_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output kara_state_e state_q,
    output kara_term_e  term_sel,
    output logic        take_ops,
    output logic        cap_h,
    output logic        cap_l,
    output logic        cap_m,
    output logic        load_res,
    output logic        done
);

    kara_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_MUL_H : ST_IDLE;
            ST_MUL_H: state_d = ST_MUL_L;
            ST_MUL_L: state_d = ST_MUL_M;
            ST_MUL_M: state_d = ST_COMB;
            ST_COMB:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        term_sel = TERM_H;
        take_ops = 1'b0;
        cap_h    = 1'b0;
        cap_l    = 1'b0;
        cap_m    = 1'b0;
        load_res = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  take_ops = start;
            ST_MUL_H: begin
                term_sel = TERM_H;
                cap_h    = 1'b1;
            end
            ST_MUL_L: begin
                term_sel = TERM_L;
                cap_l    = 1'b1;
            end
            ST_MUL_M: begin
                term_sel = TERM_M;
                cap_m    = 1'b1;
            end
            ST_COMB:  load_res = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/kara_operands.sv
module kara_operands
    import kara_pkg::*;
#(
    parameter int DIGIT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take_ops,
    input  logic [2*DIGIT_W-1:0]      op_a,
    input  logic [2*DIGIT_W-1:0]      op_b,
    input  kara_term_e                term_sel,
    output logic signed [DIGIT_W:0]   mul_x,
    output logic signed [DIGIT_W:0]   mul_y,
    output logic signed [DIGIT_W:0]   diff_a,
    output logic signed [DIGIT_W:0]   diff_b
);

    localparam int OP_W = 2 * DIGIT_W;

    logic [OP_W-1:0]    a_q;
    logic [OP_W-1:0]    b_q;
    logic [DIGIT_W-1:0] a_hi, a_lo, b_hi, b_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (take_ops) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    assign a_hi = a_q[OP_W-1:DIGIT_W];
    assign a_lo = a_q[DIGIT_W-1:0];
    assign b_hi = b_q[OP_W-1:DIGIT_W];
    assign b_lo = b_q[DIGIT_W-1:0];

    // signed byte differences, one extra bit for the sign
    assign diff_a = $signed({1'b0, a_hi}) - $signed({1'b0, a_lo});
    assign diff_b = $signed({1'b0, b_lo}) - $signed({1'b0, b_hi});

    always_comb begin
        mul_x = '0;
        mul_y = '0;
        unique case (term_sel)
            TERM_H: begin
                mul_x = $signed({1'b0, a_hi});
                mul_y = $signed({1'b0, b_hi});
            end
            TERM_L: begin
                mul_x = $signed({1'b0, a_lo});
                mul_y = $signed({1'b0, b_lo});
            end
            TERM_M: begin
                mul_x = diff_a;
                mul_y = diff_b;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/kara_smul.sv
module kara_smul #(
    parameter int IN_W = 9
) (
    input  logic signed [IN_W-1:0]   x,
    input  logic signed [IN_W-1:0]   y,
    output logic signed [2*IN_W-1:0] p
);

    assign p = x * y;

endmodule

// File: rtl/kara_recomb.sv
module kara_recomb #(
    parameter int DIGIT_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cap_h,
    input  logic                                cap_l,
    input  logic                                cap_m,
    input  logic                                load_res,
    input  logic signed [2*DIGIT_W+1:0]         sub_p,
    output logic signed [4*DIGIT_W+1:0]         acc,
    output logic [4*DIGIT_W-1:0]                product
);

    localparam int SP_W  = 2 * DIGIT_W + 2;
    localparam int PW    = 4 * DIGIT_W;
    localparam int ACC_W = PW + 2;
    localparam int EXT_W = ACC_W - SP_W;

    logic signed [SP_W-1:0]  h_q, l_q, m_q;
    logic signed [ACC_W-1:0] h_x, l_x, m_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            l_q <= '0;
            m_q <= '0;
        end else begin
            if (cap_h) h_q <= sub_p;
            if (cap_l) l_q <= sub_p;
            if (cap_m) m_q <= sub_p;
        end
    end

    assign h_x = {{EXT_W{h_q[SP_W-1]}}, h_q};
    assign l_x = {{EXT_W{l_q[SP_W-1]}}, l_q};
    assign m_x = {{EXT_W{m_q[SP_W-1]}}, m_q};

    // H*(2^2D + 2^D) + M*2^D + L*(2^D + 1)
    assign acc = (h_x <<< (2*DIGIT_W)) + (h_x <<< DIGIT_W)
               + (m_x <<< DIGIT_W)
               + (l_x <<< DIGIT_W) + l_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            product <= '0;
        end else if (load_res) begin
            product <= acc[PW-1:0];
        end
    end

endmodule

// File: rtl/kara_mul16.sv
module kara_mul16
    import kara_pkg::*;
#(
    parameter int DIGIT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2*DIGIT_W-1:0]   op_a,
    input  logic [2*DIGIT_W-1:0]   op_b,
    output logic                   done,
    output logic [4*DIGIT_W-1:0]   product
);

    localparam int IN_W  = DIGIT_W + 1;
    localparam int SP_W  = 2 * IN_W;
    localparam int ACC_W = 4 * DIGIT_W + 2;

    kara_state_e             state_q;
    kara_term_e              term_sel;
    logic                    take_ops, cap_h, cap_l, cap_m, load_res;
    logic signed [IN_W-1:0]  mul_x, mul_y, diff_a, diff_b;
    logic signed [SP_W-1:0]  sub_p;
    logic signed [ACC_W-1:0] acc_w;

    kara_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .state_q  (state_q),
        .term_sel (term_sel),
        .take_ops (take_ops),
        .cap_h    (cap_h),
        .cap_l    (cap_l),
        .cap_m    (cap_m),
        .load_res (load_res),
        .done     (done)
    );

    kara_operands #(.DIGIT_W(DIGIT_W)) u_ops (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_ops (take_ops),
        .op_a     (op_a),
        .op_b     (op_b),
        .term_sel (term_sel),
        .mul_x    (mul_x),
        .mul_y    (mul_y),
        .diff_a   (diff_a),
        .diff_b   (diff_b)
    );

    kara_smul #(.IN_W(IN_W)) u_mul (
        .x (mul_x),
        .y (mul_y),
        .p (sub_p)
    );

    kara_recomb #(.DIGIT_W(DIGIT_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_h    (cap_h),
        .cap_l    (cap_l),
        .cap_m    (cap_m),
        .load_res (load_res),
        .sub_p    (sub_p),
        .acc      (acc_w),
        .product  (product)
    );

endmodule

// File: rtl/kara_mul16_chk.sv
module kara_mul16_chk
    import kara_pkg::*;
#(
    parameter int DIGIT_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        done,
    input logic [4*DIGIT_W-1:0]        product,
    input kara_state_e                 state_q,
    input logic signed [4*DIGIT_W+1:0] acc,
    input logic signed [DIGIT_W:0]     diff_a,
    input logic signed [DIGIT_W:0]     diff_b
);

    localparam int PW    = 4 * DIGIT_W;
    localparam int ACC_W = PW + 2;
    localparam logic [DIGIT_W:0] MOST_NEG = {1'b1, {DIGIT_W{1'b0}}};

    // R6: a start in IDLE is taken at once
    a_r6_accept_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_MUL_H));

    // R5: starts while busy do not disturb the sequence
    a_r5_h_to_l: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_H) |=> (state_q == ST_MUL_L));
    a_r5_l_to_m: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_L) |=> (state_q == ST_MUL_M));
    a_r5_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R3: done follows recombination and lasts one cycle
    a_r3_done_after_comb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMB) |=> done);
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: product only changes when leaving COMB
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMB) |=> $stable(product));

    // R10: accumulator stays within unsigned 32-bit range
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMB) |-> (acc[ACC_W-1:PW] == '0));

    // R9: byte differences never reach the unused code -256
    a_r9_diff_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_M) |-> (diff_a != MOST_NEG && diff_b != MOST_NEG));

endmodule

bind kara_mul16 kara_mul16_chk #(.DIGIT_W(DIGIT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .product (product),
    .state_q (state_q),
    .acc     (acc_w),
    .diff_a  (diff_a),
    .diff_b  (diff_b)
);

// File: tb/kara_mul16_tb.sv
module kara_mul16_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        done;
    logic [31:0] product;

    int    n_checks = 0;
    int    n_fail = 0;
    int    busy_cnt = 0;
    logic [31:0] pend_prod = '0;
    logic [31:0] model_prod = '0;
    string cur_req = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    kara_mul16 u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .done    (done),
        .product (product)
    );

    // behavioural reference: a countdown and a plain multiply
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt   = 0;
            model_prod = '0;
        end else if (busy_cnt == 0) begin
            if (start) begin
                pend_prod = 32'(op_a) * 32'(op_b);
                busy_cnt  = 5;
            end
        end else begin
            busy_cnt = busy_cnt - 1;
            if (busy_cnt == 1) model_prod = pend_prod;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        logic exp_done;
        string tag;
        exp_done = (busy_cnt == 1);
        n_checks++;
        if (done !== exp_done) begin
            n_fail++;
            $display("FAIL %s done: got %b expected %b", rst_n ? "R3" : "R1", done, exp_done);
        end
        n_checks++;
        if (!rst_n) tag = "R1";
        else if (exp_done) tag = cur_req;
        else tag = "R4";
        if (product !== model_prod) begin
            n_fail++;
            $display("FAIL %s product: got %h expected %h", tag, product, model_prod);
        end
    end

    task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                          input string req, input bit noisy);
        @(negedge clk);
        cur_req = req;
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            // R5/R6: stray starts and operand changes while busy
            start = noisy ? 1'($urandom_range(0, 1)) : 1'b0;
            op_a  = noisy ? 16'($urandom) : op_a;
            op_b  = noisy ? 16'($urandom) : op_b;
        end
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state, and first cycle out of reset
        repeat (3) @(negedge clk);
        n_checks++;
        if (done !== 1'b0 || product !== 32'h0) begin
            n_fail++;
            $display("FAIL R1 reset: got done=%b product=%h expected 0/0", done, product);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R7: zero operands
        run_op(16'h0000, 16'hBEEF, "R7", 1'b0);
        run_op(16'h1234, 16'h0000, "R7", 1'b0);
        run_op(16'h0000, 16'h0000, "R7", 1'b0);
        // R8: all ones, expected 0xFFFE0001
        run_op(16'hFFFF, 16'hFFFF, "R8", 1'b0);
        // R9: mixed signs (a_hi<a_lo, b_lo>b_hi) and the reverse, same signs
        run_op(16'h10F0, 16'h20F0, "R9", 1'b0);
        run_op(16'hF010, 16'hF020, "R9", 1'b0);
        run_op(16'h10F0, 16'hF020, "R9", 1'b0);
        run_op(16'h00FF, 16'h00FF, "R9", 1'b0);
        // R10: most negative cross term, 0xFF00*0xFF00 = 0xFE010000
        run_op(16'hFF00, 16'hFF00, "R10", 1'b0);
        run_op(16'hFF00, 16'h00FF, "R10", 1'b0);
        // R5/R6: stray starts and operand changes while busy
        run_op(16'h1234, 16'h5678, "R6", 1'b1);
        run_op(16'hFFFF, 16'hFFFF, "R5", 1'b1);
        // R2: random pairs with noise
        for (int k = 0; k < 3000; k++) begin
            run_op(16'($urandom), 16'($urandom), "R2", k[0]);
        end
        repeat (4) @(negedge clk);
        summary();
    end

endmodule